// File: doc/BRIEF.md
# Streaming Foreground Blob Bounding-Box Extractor

This block sits after a background-model comparison stage and watches a raster stream of pixels, one per qualified cycle, for a frame of `W` columns by `H` rows (800 by 600 unless overridden). Each pixel counts as foreground when it differs from its background value by more than a threshold input that stays constant. Foreground pixels that touch, including diagonal contact, are grouped into objects in a single pass. Only one row of labels is kept, in a line buffer. Each provisional label owns a running box (column and row extremes plus a pixel count). When two labels meet on one pixel, the smaller label absorbs the larger one.

After the end-of-line marker of the last row, the block walks its label table in ascending order. It emits one record per object whose box is at least `MIN_W` columns wide and `MIN_H` rows tall, and stops emitting after `MAX_OBJ` records. Records leave through a valid/ready handshake. A one-cycle done pulse follows the last record. The label table has `LABELS` entries (label 0 means background). When they are all in use, further new objects join the root of the last label and a sticky flag is raised.

Top module: `blob_bbox_extractor`

## Requirements
- R1: A pixel is foreground exactly when |pix - bg| > thr, in either sign. A difference equal to thr is background.
- R2: Foreground pixels connected through any of the 8 neighbours, including diagonals, form one object and produce one record.
- R3: Shapes whose branches first appear as separate pieces and join further down (U and V shapes) are reported as a single record that covers the union of the pieces.
- R4: A record carries the inclusive minimum and maximum column and row of the object and its foreground pixel count. The column is the pixel's index after the start-of-frame pixel or after an end-of-line pixel. The row counts end-of-line markers since start of frame. Both start at 0.
- R5: A record is emitted only if its width (x_max - x_min + 1) is at least MIN_W and its height (y_max - y_min + 1) is at least MIN_H. An object exactly at that size is kept.
- R6: Records come out in the raster order of each object's first scanned pixel, and at most MAX_OBJ records are emitted per frame. Objects after the cap are dropped.
- R7: While obj_valid is high and obj_ready is low, obj_valid and every record field hold their values.
- R8: obj_valid stays low while the frame is being scanned. frame_done is a single-cycle pulse that comes after the last record is accepted, or after the frame ends with no records, and is never high together with obj_valid.
- R9: When more than LABELS-1 provisional labels are needed in a frame, overflow is set. It stays set until the next start-of-frame pixel clears it.
- R10: Cycles with pix_valid low are ignored. Pixels before a start-of-frame pixel are ignored. Pixels that arrive while records are being emitted are ignored.
- R11: After reset, obj_valid, frame_done and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Qualifies pix, sof and eol this cycle |
| sof | input | 1 | Marks the first pixel of a frame |
| eol | input | 1 | Marks the last pixel of a row |
| pix | input | PW | Current pixel value |
| bg | input | PW | Background value for this pixel |
| thr | input | PW | Foreground threshold, held constant |
| obj_ready | input | 1 | Consumer accepts the record |
| obj_valid | output | 1 | Record is presented |
| obj_x_min | output | $clog2(W) | Leftmost column of the object |
| obj_x_max | output | $clog2(W) | Rightmost column of the object |
| obj_y_min | output | $clog2(H) | Top row of the object |
| obj_y_max | output | $clog2(H) | Bottom row of the object |
| obj_area | output | $clog2(W*H+1) | Foreground pixel count |
| frame_done | output | 1 | One-cycle pulse after the record list ends |
| overflow | output | 1 | Label table was exhausted in this frame |

## Verification
The assertions assume a well-formed frame stream: sof only on the first pixel, eol exactly on column W-1, exactly H rows, and thr held constant during a frame. Under those conditions every emitted box lies inside the frame and has an area no larger than its rectangle. The bench builds every frame to that exact shape. It places idle cycles and stray foreground-looking pixels only where they must be ignored: with pix_valid low, before the start-of-frame pixel, or during record emission. It exercises label exhaustion with many isolated dots, and in that frame it checks only the flag and the handshake, because merged overflow labels no longer follow connectivity.

// File: rtl/blob_pkg.sv
package blob_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

endpackage

// File: rtl/blob_fg_detect.sv
module blob_fg_detect #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] pix,
    input  logic [PW-1:0] bg,
    input  logic [PW-1:0] thr,
    output logic          fg
);
    logic [PW-1:0] diff;

    always_comb begin
        diff = (pix >= bg) ? (pix - bg) : (bg - pix);
        fg   = diff > thr;
    end
endmodule

// File: rtl/blob_line_buf.sv
module blob_line_buf #(
    parameter int W  = 800,
    parameter int LW = 6,
    localparam int XW = $clog2(W)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [XW-1:0] addr,
    input  logic [LW-1:0] wr_data,
    output logic [LW-1:0] rd_mid,
    output logic [LW-1:0] rd_right
);
    logic [LW-1:0] row_q [W];

    always_comb begin
        rd_mid   = row_q[addr];
        rd_right = (addr == XW'(W - 1)) ? '0 : row_q[addr + 1'b1];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_q[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/blob_obj_filter.sv
module blob_obj_filter #(
    parameter int W       = 800,
    parameter int H       = 600,
    parameter int MIN_W   = 25,
    parameter int MIN_H   = 20,
    parameter int MAX_OBJ = 10,
    localparam int XW = $clog2(W),
    localparam int YW = $clog2(H),
    localparam int CW = $clog2(MAX_OBJ + 1)
) (
    input  logic          vld,
    input  logic [XW-1:0] x0,
    input  logic [XW-1:0] x1,
    input  logic [YW-1:0] y0,
    input  logic [YW-1:0] y1,
    input  logic [CW-1:0] sent,
    output logic          keep
);
    logic [XW:0] span_x;
    logic [YW:0] span_y;

    always_comb begin
        span_x = {1'b0, x1} - {1'b0, x0} + 1'b1;
        span_y = {1'b0, y1} - {1'b0, y0} + 1'b1;
        keep   = vld
              && (span_x >= (XW+1)'(MIN_W))
              && (span_y >= (YW+1)'(MIN_H))
              && (sent < CW'(MAX_OBJ));
    end
endmodule

// File: rtl/blob_bbox_extractor.sv
module blob_bbox_extractor
    import blob_pkg::*;
#(
    parameter int W       = 800,
    parameter int H       = 600,
    parameter int PW      = 8,
    parameter int LABELS  = 64,
    parameter int MIN_W   = 25,
    parameter int MIN_H   = 20,
    parameter int MAX_OBJ = 10,
    localparam int XW = $clog2(W),
    localparam int YW = $clog2(H),
    localparam int AW = $clog2(W * H + 1),
    localparam int LW = $clog2(LABELS),
    localparam int CW = $clog2(MAX_OBJ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          sof,
    input  logic          eol,
    input  logic [PW-1:0] pix,
    input  logic [PW-1:0] bg,
    input  logic [PW-1:0] thr,
    input  logic          obj_ready,
    output logic          obj_valid,
    output logic [XW-1:0] obj_x_min,
    output logic [XW-1:0] obj_x_max,
    output logic [YW-1:0] obj_y_min,
    output logic [YW-1:0] obj_y_max,
    output logic [AW-1:0] obj_area,
    output logic          frame_done,
    output logic          overflow
);
    localparam logic [LW-1:0] LAST_LBL = LW'(LABELS - 1);

    typedef struct packed {
        logic          vld;
        logic [XW-1:0] x0;
        logic [XW-1:0] x1;
        logic [YW-1:0] y0;
        logic [YW-1:0] y1;
        logic [AW-1:0] area;
    } box_t;

    typedef struct packed {
        phase_e        ph;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [LW-1:0] left;
        logic [LW-1:0] above_l;
        logic [LW:0]   next_free;
        logic          ovf;
        logic [LW-1:0] idx;
        logic [CW-1:0] sent;
        logic          done;
    } ctl_t;

    ctl_t          c_q, c_d;
    box_t          box_q [LABELS];
    box_t          box_d [LABELS];
    logic [LW-1:0] par_q [LABELS];
    logic [LW-1:0] par_d [LABELS];

    logic          fg;
    logic          take;
    logic          keep;
    logic          lb_we;
    logic [LW-1:0] lb_wd;
    logic [LW-1:0] lb_mid, lb_right;
    logic [XW-1:0] px;
    logic [YW-1:0] py;
    logic [LW-1:0] n_l, n_al, n_a, n_ar;
    logic [LW-1:0] r_l, r_al, r_a, r_ar;
    logic [LW-1:0] grp, win, lose, tgt, lbl;
    box_t          base, cand;

    function automatic logic [LW-1:0] min_nz(input logic [LW-1:0] a, input logic [LW-1:0] b);
        if (a == '0)     return b;
        else if (b == '0) return a;
        else             return (a < b) ? a : b;
    endfunction

    function automatic box_t unite(input box_t a, input box_t b);
        box_t r;
        if (!a.vld) return b;
        if (!b.vld) return a;
        r.vld  = 1'b1;
        r.x0   = (a.x0 < b.x0) ? a.x0 : b.x0;
        r.x1   = (a.x1 > b.x1) ? a.x1 : b.x1;
        r.y0   = (a.y0 < b.y0) ? a.y0 : b.y0;
        r.y1   = (a.y1 > b.y1) ? a.y1 : b.y1;
        r.area = a.area + b.area;
        return r;
    endfunction

    function automatic box_t add_point(input box_t a, input logic [XW-1:0] x, input logic [YW-1:0] y);
        box_t p;
        p.vld  = 1'b1;
        p.x0   = x;
        p.x1   = x;
        p.y0   = y;
        p.y1   = y;
        p.area = AW'(1);
        return unite(a, p);
    endfunction

    blob_fg_detect #(.PW(PW)) u_fg (
        .pix (pix),
        .bg  (bg),
        .thr (thr),
        .fg  (fg)
    );

    blob_line_buf #(.W(W), .LW(LW)) u_line (
        .clk      (clk),
        .wr_en    (lb_we),
        .addr     (px),
        .wr_data  (lb_wd),
        .rd_mid   (lb_mid),
        .rd_right (lb_right)
    );

    assign cand = box_q[c_q.idx];

    blob_obj_filter #(
        .W(W), .H(H), .MIN_W(MIN_W), .MIN_H(MIN_H), .MAX_OBJ(MAX_OBJ)
    ) u_filt (
        .vld  (cand.vld),
        .x0   (cand.x0),
        .x1   (cand.x1),
        .y0   (cand.y0),
        .y1   (cand.y1),
        .sent (c_q.sent),
        .keep (keep)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        box_d    = box_q;
        par_d    = par_q;
        lb_we    = 1'b0;
        lb_wd    = '0;
        lbl      = '0;
        tgt      = '0;
        base     = '0;

        take = pix_valid && ((c_q.ph == PH_IDLE && sof) || c_q.ph == PH_SCAN);
        px   = (c_q.ph == PH_SCAN) ? c_q.x : '0;
        py   = (c_q.ph == PH_SCAN) ? c_q.y : '0;

        // neighbour labels, masked at the frame edges
        n_l  = (px == '0) ? '0 : c_q.left;
        n_al = (px == '0 || py == '0) ? '0 : c_q.above_l;
        n_a  = (py == '0) ? '0 : lb_mid;
        n_ar = (py == '0) ? '0 : lb_right;
        r_l  = (n_l  == '0) ? '0 : par_q[n_l];
        r_al = (n_al == '0) ? '0 : par_q[n_al];
        r_a  = (n_a  == '0) ? '0 : par_q[n_a];
        r_ar = (n_ar == '0) ? '0 : par_q[n_ar];
        grp  = min_nz(min_nz(r_l, r_al), r_a);
        win  = min_nz(grp, r_ar);
        lose = (grp != '0 && r_ar != '0 && grp != r_ar) ? ((grp > r_ar) ? grp : r_ar) : '0;

        if (take) begin
            if (c_q.ph == PH_IDLE) begin
                c_d.ovf = 1'b0;
            end
            if (fg) begin
                if (win == '0) begin
                    if (c_q.next_free == (LW+1)'(LABELS)) begin
                        tgt     = par_q[LAST_LBL];
                        c_d.ovf = 1'b1;
                    end else begin
                        tgt           = c_q.next_free[LW-1:0];
                        c_d.next_free = c_q.next_free + 1'b1;
                    end
                end else begin
                    tgt = win;
                end
                base = box_q[tgt];
                if (lose != '0) begin
                    base            = unite(base, box_q[lose]);
                    box_d[lose].vld = 1'b0;
                    for (int i = 0; i < LABELS; i++) begin
                        if (par_q[i] == lose) par_d[i] = win;
                    end
                end
                box_d[tgt] = add_point(base, px, py);
                lbl        = tgt;
            end
            lb_we       = 1'b1;
            lb_wd       = lbl;
            c_d.left    = lbl;
            c_d.above_l = lb_mid;
            if (eol) begin
                c_d.x = '0;
                if (py == YW'(H - 1)) begin
                    c_d.ph   = PH_EMIT;
                    c_d.idx  = LW'(1);
                    c_d.sent = '0;
                end else begin
                    c_d.ph = PH_SCAN;
                    c_d.y  = py + 1'b1;
                end
            end else begin
                c_d.ph = PH_SCAN;
                c_d.x  = px + 1'b1;
                c_d.y  = py;
            end
        end

        if (c_q.ph == PH_EMIT && (!keep || obj_ready)) begin
            if (keep) c_d.sent = c_q.sent + 1'b1;
            if (c_q.idx == LAST_LBL) begin
                c_d.ph        = PH_IDLE;
                c_d.done      = 1'b1;
                c_d.next_free = (LW+1)'(1);
                c_d.x         = '0;
                c_d.y         = '0;
                for (int i = 0; i < LABELS; i++) begin
                    box_d[i].vld = 1'b0;
                    par_d[i]     = LW'(i);
                end
            end else begin
                c_d.idx = c_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q           <= '0;
            c_q.ph        <= PH_IDLE;
            c_q.next_free <= (LW+1)'(1);
            c_q.idx       <= LW'(1);
            for (int i = 0; i < LABELS; i++) begin
                box_q[i] <= '0;
                par_q[i] <= LW'(i);
            end
        end else begin
            c_q <= c_d;
            for (int i = 0; i < LABELS; i++) begin
                box_q[i] <= box_d[i];
                par_q[i] <= par_d[i];
            end
        end
    end

    assign obj_valid  = (c_q.ph == PH_EMIT) && keep;
    assign obj_x_min  = cand.x0;
    assign obj_x_max  = cand.x1;
    assign obj_y_min  = cand.y0;
    assign obj_y_max  = cand.y1;
    assign obj_area   = cand.area;
    assign frame_done = c_q.done;
    assign overflow   = c_q.ovf;

endmodule

// File: rtl/blob_bbox_checker.sv
module blob_bbox_checker #(
    parameter int W       = 800,
    parameter int H       = 600,
    parameter int MIN_W   = 25,
    parameter int MIN_H   = 20,
    parameter int MAX_OBJ = 10,
    parameter int XW      = 10,
    parameter int YW      = 10,
    parameter int AW      = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          sof,
    input logic          obj_valid,
    input logic          obj_ready,
    input logic [XW-1:0] obj_x_min,
    input logic [XW-1:0] obj_x_max,
    input logic [YW-1:0] obj_y_min,
    input logic [YW-1:0] obj_y_max,
    input logic [AW-1:0] obj_area,
    input logic          frame_done,
    input logic          overflow
);
    int hs_cnt;
    int span_x, span_y;

    always_comb begin
        span_x = int'(obj_x_max) - int'(obj_x_min) + 1;
        span_y = int'(obj_y_max) - int'(obj_y_min) + 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      hs_cnt <= 0;
        else if (frame_done)             hs_cnt <= 0;
        else if (obj_valid && obj_ready) hs_cnt <= hs_cnt + 1;
    end

    a_r4_box_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid |-> (obj_x_min <= obj_x_max) && (obj_y_min <= obj_y_max)
                      && (int'(obj_x_max) < W) && (int'(obj_y_max) < H)
                      && (obj_area != '0) && (int'(obj_area) <= span_x * span_y));

    a_r5_min_size: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid |-> (span_x >= MIN_W) && (span_y >= MIN_H));

    a_r6_record_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_valid && obj_ready) |-> (hs_cnt < MAX_OBJ));

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_valid && !obj_ready) |=> obj_valid && $stable(obj_x_min) && $stable(obj_x_max)
                                      && $stable(obj_y_min) && $stable(obj_y_max) && $stable(obj_area));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r8_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !obj_valid);

    a_r9_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(pix_valid && sof)) |=> overflow);
endmodule

bind blob_bbox_extractor blob_bbox_checker #(
    .W(W), .H(H), .MIN_W(MIN_W), .MIN_H(MIN_H), .MAX_OBJ(MAX_OBJ),
    .XW(XW), .YW(YW), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .sof        (sof),
    .obj_valid  (obj_valid),
    .obj_ready  (obj_ready),
    .obj_x_min  (obj_x_min),
    .obj_x_max  (obj_x_max),
    .obj_y_min  (obj_y_min),
    .obj_y_max  (obj_y_max),
    .obj_area   (obj_area),
    .frame_done (frame_done),
    .overflow   (overflow)
);

// File: tb/blob_bbox_extractor_bench.sv
module blob_bbox_extractor_bench;
    localparam int W = 32, H = 16, PW = 8, MIN_W = 3, MIN_H = 2, MAX_OBJ = 4;
    localparam int XW = $clog2(W), YW = $clog2(H), AW = $clog2(W * H + 1);
    localparam int BGV = 100, THR = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0, sof = 1'b0, eol = 1'b0, obj_ready = 1'b0;
    logic [PW-1:0] pix = '0, bg = PW'(BGV), thr = PW'(THR);
    logic          obj_valid, frame_done, overflow;
    logic [XW-1:0] obj_x_min, obj_x_max;
    logic [YW-1:0] obj_y_min, obj_y_max;
    logic [AW-1:0] obj_area;

    blob_bbox_extractor #(
        .W(W), .H(H), .PW(PW), .MIN_W(MIN_W), .MIN_H(MIN_H), .MAX_OBJ(MAX_OBJ)
    ) u_blob_bbox_extractor (.*);

    always #10 clk = ~clk;

    typedef struct { int x0; int x1; int y0; int y1; int area; } rec_t;
    rec_t exp_q[$];
    bit   img [H][W];
    int   checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_img();
        for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 1'b0;
    endtask

    task automatic rect(input int x0, input int y0, input int w, input int h);
        for (int y = y0; y < y0 + h; y++) for (int x = x0; x < x0 + w; x++) img[y][x] = 1'b1;
    endtask

    // reference: 8-connected flood fill in raster order, then size filter and cap
    task automatic build_expected();
        bit seen [H][W];
        exp_q.delete();
        for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) seen[y][x] = 1'b0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (img[y][x] && !seen[y][x]) begin
                    rec_t r;
                    int qx[$], qy[$];
                    r = '{x, x, y, y, 0};
                    seen[y][x] = 1'b1;
                    qx.push_back(x); qy.push_back(y);
                    while (qx.size() > 0) begin
                        int cx, cy;
                        cx = qx.pop_front(); cy = qy.pop_front();
                        r.area++;
                        if (cx < r.x0) r.x0 = cx;
                        if (cx > r.x1) r.x1 = cx;
                        if (cy < r.y0) r.y0 = cy;
                        if (cy > r.y1) r.y1 = cy;
                        for (int dy = -1; dy <= 1; dy++) begin
                            for (int dx = -1; dx <= 1; dx++) begin
                                int nx, ny;
                                nx = cx + dx; ny = cy + dy;
                                if (nx >= 0 && nx < W && ny >= 0 && ny < H) begin
                                    if (img[ny][nx] && !seen[ny][nx]) begin
                                        seen[ny][nx] = 1'b1;
                                        qx.push_back(nx); qy.push_back(ny);
                                    end
                                end
                            end
                        end
                    end
                    if ((r.x1 - r.x0 + 1) >= MIN_W && (r.y1 - r.y0 + 1) >= MIN_H
                        && exp_q.size() < MAX_OBJ) exp_q.push_back(r);
                end
            end
        end
    endtask

    function automatic int pix_value(input bit f, input int x, input int y);
        if (f) return ((x + y) % 2 == 1) ? BGV + THR + 1 + (x % 4) : BGV - THR - 1 - (y % 4);
        if (x % 3 == 0) return BGV + THR;   // exactly at threshold: background (R1)
        if (x % 3 == 1) return BGV - THR;
        return BGV + (x % 7);
    endfunction

    task automatic send_frame(input bit gaps);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (gaps && ((x + y) % 7 == 3)) begin
                    @(negedge clk);
                    pix_valid = 1'b0; sof = 1'b1; eol = 1'b1;   // ignored cycle (R10)
                    pix = PW'(BGV + 90);
                end
                @(negedge clk);
                check(obj_valid == 1'b0, "R8 no record during scan", obj_valid, 0);
                pix_valid = 1'b1;
                sof = (x == 0 && y == 0);
                eol = (x == W - 1);
                pix = PW'(pix_value(img[y][x], x, y));
            end
        end
        @(negedge clk);
        pix_valid = 1'b0; sof = 1'b0; eol = 1'b0;
    endtask

    task automatic drain(input bit compare, input bit junk, output bit ovf_seen);
        bit got_done = 1'b0, stalled = 1'b0;
        int px0 = 0, px1 = 0, py0 = 0, py1 = 0, par = 0;
        ovf_seen = 1'b0;
        for (int cyc = 0; cyc < 3000 && !got_done; cyc++) begin
            @(negedge clk);
            if (junk) begin
                pix_valid = 1'b1; sof = (cyc % 5 == 0); eol = 1'b0;
                pix = PW'(BGV + 60);
            end
            if (frame_done) begin
                got_done = 1'b1;
                ovf_seen = overflow;
                check(obj_valid == 1'b0, "R8 done without record", obj_valid, 0);
                if (compare) check(exp_q.size() == 0, "R6 all expected records seen", exp_q.size(), 0);
                obj_ready = 1'b0;
            end else if (obj_valid) begin
                if (stalled) begin
                    check(int'(obj_x_min) == px0 && int'(obj_x_max) == px1 && int'(obj_y_min) == py0
                          && int'(obj_y_max) == py1 && int'(obj_area) == par,
                          "R7 fields held while stalled", int'(obj_x_min), px0);
                end
                obj_ready = (cyc % 3 != 1);
                stalled = !obj_ready;
                px0 = int'(obj_x_min); px1 = int'(obj_x_max);
                py0 = int'(obj_y_min); py1 = int'(obj_y_max); par = int'(obj_area);
                if (obj_ready && compare) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 extra record", 1, 0);
                    end else begin
                        rec_t e;
                        e = exp_q.pop_front();
                        check(px0 == e.x0, "R4 x_min", px0, e.x0);
                        check(px1 == e.x1, "R4 x_max", px1, e.x1);
                        check(py0 == e.y0, "R4 y_min", py0, e.y0);
                        check(py1 == e.y1, "R4 y_max", py1, e.y1);
                        check(par == e.area, "R4 area", par, e.area);
                    end
                end
            end else begin
                obj_ready = (cyc % 2 == 0);
                stalled = 1'b0;
            end
        end
        pix_valid = 1'b0; sof = 1'b0;
        check(got_done, "R8 frame_done seen", got_done, 1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog R8 actual=timeout expected=frame_done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ovf;
        repeat (3) @(negedge clk);
        check(obj_valid == 1'b0, "R11 obj_valid after reset", obj_valid, 0);
        check(frame_done == 1'b0, "R11 frame_done after reset", frame_done, 0);
        check(overflow == 1'b0, "R11 overflow after reset", overflow, 0);
        rst_n = 1'b1;

        // stray pixels before any start of frame (R10)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; sof = 1'b0; eol = (i == 5); pix = PW'(BGV + 80);
        end
        @(negedge clk); pix_valid = 1'b0; eol = 1'b0;
        check(obj_valid == 1'b0 && frame_done == 1'b0, "R10 idle pixels ignored", obj_valid, 0);

        // frame 1: rectangles, diagonal line, boundary sizes (R1 R2 R4 R5 R10)
        clear_img();
        rect(2, 1, 5, 3);
        for (int i = 0; i < 6; i++) img[2 + i][10 + i] = 1'b1;
        rect(20, 1, 2, 1);
        rect(25, 8, 1, 5);
        rect(28, 12, 3, 2);
        rect(6, 10, 3, 1);
        build_expected();
        check(exp_q.size() == 3, "R5 reference count frame 1", exp_q.size(), 3);
        send_frame(1'b1);
        drain(1'b1, 1'b1, ovf);

        // frame 2: U and V shapes that join lower down (R3)
        clear_img();
        rect(4, 2, 1, 8); rect(8, 2, 1, 8); rect(4, 9, 5, 1);
        for (int i = 0; i < 5; i++) begin
            img[2 + i][14 + i] = 1'b1;
            img[2 + i][22 - i] = 1'b1;
        end
        rect(26, 1, 1, 3); rect(29, 0, 1, 4); rect(27, 4, 2, 1);
        build_expected();
        check(exp_q.size() == 3, "R3 reference count frame 2", exp_q.size(), 3);
        send_frame(1'b0);
        drain(1'b1, 1'b0, ovf);

        // frame 3: more qualifying objects than the cap (R6)
        clear_img();
        rect(0, 1, 2, 1);
        for (int k = 0; k < 6; k++) rect(1 + 5 * k, 3, 3, 2);
        rect(2, 10, 4, 3);
        build_expected();
        check(exp_q.size() == MAX_OBJ, "R6 reference capped", exp_q.size(), MAX_OBJ);
        send_frame(1'b1);
        drain(1'b1, 1'b0, ovf);
        check(ovf == 1'b0, "R9 no overflow on small frame", ovf, 0);

        // frame 4: isolated dots exhaust the label table (R9)
        clear_img();
        for (int y = 0; y < H; y += 2) for (int x = 0; x < W; x += 2) img[y][x] = 1'b1;
        send_frame(1'b0);
        drain(1'b0, 1'b0, ovf);
        check(ovf == 1'b1, "R9 overflow raised", ovf, 1);
        repeat (4) @(negedge clk);
        check(overflow == 1'b1, "R9 overflow sticky until sof", overflow, 1);

        // frame 5: empty frame clears the flag and reports nothing (R8 R9)
        clear_img();
        build_expected();
        send_frame(1'b0);
        check(overflow == 1'b0, "R9 overflow cleared by sof", overflow, 0);
        drain(1'b1, 1'b0, ovf);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule